// File: doc/BRIEF.md
# Program/Erase Busy and Toggle Status Tracker

This block stands in for the timing side of an embedded program or erase operation in a nonvolatile memory controller. When the command decoder has accepted a complete program sequence (four write pulses) or any erase sequence (six write pulses), it sends a single-cycle start pulse with the operation type. The block then holds itself busy for a number of clock cycles that depends on that type. While it is busy, a host read does not return array data. Instead it returns a status word whose bit 6 inverts on every read, so software can poll until the bit stops changing.

When the operation finishes, the block accepts new commands at once. Read data is only marked valid after a bus recovery window. An active-low reset pin is filtered by width. A low pulse long enough aborts any running operation, and the block holds off reads until a recovery time after the pin is released. If the aborted operation was an erase, a sticky flag tells the host that the erase must be issued again.

The state machine has five states. READY passes reads through. BUSY serves toggle status. RECOVER waits out bus recovery and still accepts commands. PIN_HOLD lasts while the pin stays low after an abort. PIN_REC covers the recovery time after release. The transitions are:
- start: READY or RECOVER to BUSY.
- done: BUSY to RECOVER.
- settle: RECOVER to READY.
- abort: any state to PIN_HOLD.
- release: PIN_HOLD to PIN_REC.
- resume: PIN_REC to READY.

Top module: `pe_busy_status`

## Requirements
- R1: After system reset the block is in READY: `ready_o`=1, `erase_redo_o`=0, and a read is flagged valid.
- R2: A start accepted with `op_i` = 0 (program), 1 (sector erase), 2 (block erase) or 3 (chip erase) makes `ready_o` low for exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles respectively, starting the cycle after the start.
- R3: While busy, `rd_data_o` is all zeros except bit 6. Bit 6 is 0 for the first read after a start and inverts on each later read. Cycles with no read leave it unchanged.
- R4: A start pulse arriving while busy is ignored and does not change the remaining busy time.
- R5: When busy ends, `ready_o` rises at once. For the next RECOV_CYC cycles, reads are not flagged valid, and `rd_data_o` carries array data with no toggling bit.
- R6: A start arriving during the recovery window is accepted and starts a new busy period.
- R7: The reset pin must be sampled low for PULSE_MIN consecutive cycles to abort. A shorter low pulse has no effect on state, busy time or outputs.
- R8: After an abort, `ready_o` and `rd_valid_o` stay low while the pin is low and for RELEASE_CYC cycles after it goes high. The block then returns to READY.
- R9: An abort that hits a busy erase (op 1 to 3) sets `erase_redo_o`. An abort of a program does not. The flag clears when a new erase start is accepted.
- R10: Outside BUSY, `rd_data_o` equals `array_data_i` unchanged. In READY, `rd_valid_o` follows `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Single-cycle start from the command decoder |
| op_i | input | 2 | Operation type: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| rd_i | input | 1 | Host read strobe, one per read |
| reset_pin_n_i | input | 1 | Synchronised active-low hardware reset pin |
| array_data_i | input | DW | Data read from the array |
| rd_data_o | output | DW | Read return: status word while busy, array data otherwise |
| rd_valid_o | output | 1 | The read in this cycle carries valid data |
| ready_o | output | 1 | A new command may be accepted |
| erase_redo_o | output | 1 | An erase was cut short by reset and must be reissued |

## Verification
The bench builds the block with short durations: 5, 9, 12 and 16 cycles for the four operation types, a 3-cycle recovery window, a 4-cycle minimum reset pulse and a 6-cycle release time. Every state and transition is then reachable within a few dozen cycles. With these values a 3-cycle pin pulse (ignored) and a 6-cycle pin pulse (abort) can both fall inside one chip erase. A start can be placed exactly in the recovery window, and an ignored start can land mid-erase while the total busy length is still counted.

// File: rtl/pe_stat_pkg.sv
package pe_stat_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } pe_op_e;

    typedef enum logic [2:0] {
        S_READY    = 3'd0,
        S_BUSY     = 3'd1,
        S_RECOVER  = 3'd2,
        S_PIN_HOLD = 3'd3,
        S_PIN_REC  = 3'd4
    } pe_state_e;

    localparam int TOG_BIT = 6;
    localparam int NUM_OPS = 4;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pe_pin_filter.sv
module pe_pin_filter #(
    parameter int PULSE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic abort_o
);
    localparam int LW = $clog2(PULSE_MIN + 1);
    localparam logic [LW-1:0] LIM    = LW'(PULSE_MIN);
    localparam logic [LW-1:0] LIM_M1 = LW'(PULSE_MIN - 1);

    logic [LW-1:0] low_q;

    // counts consecutive low samples, saturating so a long hold aborts once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (pin_n_i) begin
            low_q <= '0;
        end else if (low_q != LIM) begin
            low_q <= low_q + 1'b1;
        end
    end

    always_comb begin
        abort_o = !pin_n_i && (low_q == LIM_M1);
    end

    // R7: an abort needs the pin already low in the previous cycle
    p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(!pin_n_i));

    // R7: one abort per low period
    p_single_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

endmodule

// File: rtl/pe_dur_sel.sv
module pe_dur_sel
    import pe_stat_pkg::*;
#(
    parameter int CW       = 10,
    parameter int PROG_CYC = 40,
    parameter int SECT_CYC = 200,
    parameter int BLK_CYC  = 400,
    parameter int CHIP_CYC = 800
) (
    input  logic [1:0]    op_i,
    output logic [CW-1:0] dur_m1_o
);
    localparam int DUR [NUM_OPS] = '{PROG_CYC, SECT_CYC, BLK_CYC, CHIP_CYC};

    logic [CW-1:0] tab [NUM_OPS];

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_tab
        assign tab[g] = CW'(DUR[g] - 1);
    end

    always_comb begin
        dur_m1_o = tab[op_i];
    end

endmodule

// File: rtl/pe_toggle_gen.sv
module pe_toggle_gen
    import pe_stat_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    output logic [DW-1:0] status_o
);
    logic tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (clr_i) begin
            tog_q <= 1'b0;
        end else if (adv_i) begin
            tog_q <= ~tog_q;
        end
    end

    always_comb begin
        status_o          = '0;
        status_o[TOG_BIT] = tog_q;
    end

    // R3: every start leaves the toggle bit at zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (status_o[TOG_BIT] == 1'b0));

    // R3: no read, no change
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !adv_i) |=> $stable(status_o));

endmodule

// File: rtl/pe_busy_status.sv
module pe_busy_status
    import pe_stat_pkg::*;
#(
    parameter int DW          = 16,
    parameter int PROG_CYC    = 40,
    parameter int SECT_CYC    = 200,
    parameter int BLK_CYC     = 400,
    parameter int CHIP_CYC    = 800,
    parameter int RECOV_CYC   = 10,
    parameter int PULSE_MIN   = 4,
    parameter int RELEASE_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic          rd_i,
    input  logic          reset_pin_n_i,
    input  logic [DW-1:0] array_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic          ready_o,
    output logic          erase_redo_o
);
    localparam int MAXC = imax(imax(imax(PROG_CYC, SECT_CYC), imax(BLK_CYC, CHIP_CYC)),
                               imax(RECOV_CYC, RELEASE_CYC));
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RECOV_M1 = CW'(RECOV_CYC - 1);
    localparam logic [CW-1:0] REL_M1   = CW'(RELEASE_CYC - 1);

    pe_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    pe_op_e        op_q, op_d;
    logic          redo_q, redo_d;
    logic          accept;
    logic          abort;
    logic [CW-1:0] dur_m1;
    logic [DW-1:0] status_word;

    pe_pin_filter #(.PULSE_MIN(PULSE_MIN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (reset_pin_n_i),
        .abort_o (abort)
    );

    pe_dur_sel #(
        .CW(CW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
        .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
    ) u_dur (
        .op_i     (op_i),
        .dur_m1_o (dur_m1)
    );

    pe_toggle_gen #(.DW(DW)) u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept),
        .adv_i    (rd_i && (state_q == S_BUSY)),
        .status_o (status_word)
    );

    // next state: abort first, then per-state transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        op_d    = op_q;
        redo_d  = redo_q;
        accept  = 1'b0;
        if (abort) begin
            state_d = S_PIN_HOLD;
            if ((state_q == S_BUSY) && (op_q != OP_PROG)) begin
                redo_d = 1'b1;
            end
        end else begin
            unique case (state_q)
                S_READY, S_RECOVER: begin
                    if (start_i) begin
                        accept  = 1'b1;
                        state_d = S_BUSY;
                        cnt_d   = dur_m1;
                        op_d    = pe_op_e'(op_i);
                        if (pe_op_e'(op_i) != OP_PROG) begin
                            redo_d = 1'b0;
                        end
                    end else if (state_q == S_RECOVER) begin
                        if (cnt_q == '0) begin
                            state_d = S_READY;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                S_BUSY: begin
                    if (cnt_q == '0) begin
                        state_d = S_RECOVER;
                        cnt_d   = RECOV_M1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                S_PIN_HOLD: begin
                    if (reset_pin_n_i) begin
                        state_d = S_PIN_REC;
                        cnt_d   = REL_M1;
                    end
                end
                S_PIN_REC: begin
                    if (cnt_q == '0) begin
                        state_d = S_READY;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = S_READY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_READY;
            cnt_q   <= '0;
            op_q    <= OP_PROG;
            redo_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            op_q    <= op_d;
            redo_q  <= redo_d;
        end
    end

    // outputs
    always_comb begin
        ready_o      = (state_q == S_READY) || (state_q == S_RECOVER);
        rd_valid_o   = rd_i && ((state_q == S_READY) || (state_q == S_BUSY));
        rd_data_o    = (state_q == S_BUSY) ? status_word : array_data_i;
        erase_redo_o = redo_q;
    end

    // R2: an accepted start drops ready in the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && ready_o && !abort) |=> !ready_o);

    // R3: back-to-back reads while busy return opposite bit 6
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_BUSY) && rd_i && !abort) ##1 ((state_q == S_BUSY) && rd_i)
        |-> (rd_data_o[TOG_BIT] != $past(rd_data_o[TOG_BIT])));

    // R5: finishing raises ready without valid data
    p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_BUSY) && (cnt_q == '0) && !abort) |=> (ready_o && !rd_valid_o));

    // R8: an abort blocks commands and reads in the next cycle
    p_abort_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!ready_o && !rd_valid_o));

    // R9: aborting a busy erase raises the reissue flag
    p_redo_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && (state_q == S_BUSY) && (op_q != OP_PROG)) |=> erase_redo_o);

endmodule

// File: tb/sim_pe_busy_status.sv
`timescale 1ns/100ps
module sim_pe_busy_status;
    localparam int DW   = 16;
    localparam int PROG = 5;
    localparam int SECT = 9;
    localparam int BLK  = 12;
    localparam int CHIP = 16;
    localparam int RCV  = 3;
    localparam int PMIN = 4;
    localparam int REL  = 6;

    localparam int M_RDY = 0, M_BSY = 1, M_RCV = 2, M_HLD = 3, M_REL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op = 2'd0;
    logic rd = 1'b0;
    logic pin = 1'b1;
    logic [DW-1:0] arr = '0;
    logic [DW-1:0] rd_data;
    logic rd_valid, ready, redo;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string phase = "R1";

    int ms = M_RDY, mrem = 0, mlow = 0, mtog = 0, mredo = 0, mop = 0;

    always #2.5 clk = ~clk;

    pe_busy_status #(
        .DW(DW), .PROG_CYC(PROG), .SECT_CYC(SECT), .BLK_CYC(BLK), .CHIP_CYC(CHIP),
        .RECOV_CYC(RCV), .PULSE_MIN(PMIN), .RELEASE_CYC(REL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .rd_i(rd),
        .reset_pin_n_i(pin), .array_data_i(arr), .rd_data_o(rd_data),
        .rd_valid_o(rd_valid), .ready_o(ready), .erase_redo_o(redo)
    );

    function automatic int durof(input int o);
        case (o)
            0: return PROG;
            1: return SECT;
            2: return BLK;
            default: return CHIP;
        endcase
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = M_RDY; mrem = 0; mlow = 0; mtog = 0; mredo = 0; mop = 0;
        end else begin
            bit ab;
            ab = !pin && (mlow == PMIN - 1);
            if (pin) mlow = 0; else mlow = mlow + 1;
            if (ab) begin
                if (ms == M_BSY && mop != 0) mredo = 1;
                ms = M_HLD;
            end else begin
                case (ms)
                    M_RDY, M_RCV: begin
                        if (start) begin
                            ms = M_BSY; mop = int'(op); mrem = durof(int'(op)); mtog = 0;
                            if (op != 2'd0) mredo = 0;
                        end else if (ms == M_RCV) begin
                            mrem = mrem - 1;
                            if (mrem == 0) ms = M_RDY;
                        end
                    end
                    M_BSY: begin
                        if (rd) mtog = mtog ^ 1;
                        mrem = mrem - 1;
                        if (mrem == 0) begin ms = M_RCV; mrem = RCV; end
                    end
                    M_HLD: if (pin) begin ms = M_REL; mrem = REL; end
                    M_REL: begin
                        mrem = mrem - 1;
                        if (mrem == 0) ms = M_RDY;
                    end
                    default: ms = M_RDY;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s act=%h exp=%h", tag, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic exp_rdy, exp_val, exp_redo;
        logic [DW-1:0] exp_dat;
        string t;
        exp_rdy  = (ms == M_RDY) || (ms == M_RCV);
        exp_val  = rd && ((ms == M_RDY) || (ms == M_BSY));
        exp_dat  = (ms == M_BSY) ? (DW'(mtog) << 6) : arr;
        exp_redo = (mredo != 0);
        t = (ms == M_BSY) ? "R2" : (ms == M_RCV) ? "R5" : (ms == M_RDY) ? "R1" : "R8";
        chk(ready === exp_rdy, t, "ready", DW'(ready), DW'(exp_rdy));
        t = (ms == M_RCV) ? "R5" : (ms == M_RDY) ? "R10" : (ms == M_BSY) ? "R3" : "R8";
        chk(rd_valid === exp_val, t, "rd_valid", DW'(rd_valid), DW'(exp_val));
        t = (ms == M_BSY) ? "R3" : "R10";
        chk(rd_data === exp_dat, t, "rd_data", rd_data, exp_dat);
        chk(redo === exp_redo, "R9", "redo", DW'(redo), DW'(exp_redo));
    endtask

    task automatic cyc(input bit s, input logic [1:0] o, input bit r, input bit p,
                       input logic [DW-1:0] d);
        start = s; op = o; rd = r; pin = p; arr = d;
        #1;
        if (rst_n) compare();
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, r, 1'b1, DW'(16'h1234 + i * 16'h0111));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog [%s] act=hung exp=finished", phase);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ready === 1'b1, "R1", "ready after reset", DW'(ready), 1);
        chk(redo === 1'b0, "R1", "redo after reset", DW'(redo), 0);
        @(negedge clk);

        phase = "R10";
        cyc(0, 0, 1, 1, 16'hA5C3);
        cyc(0, 0, 1, 1, 16'h0040);
        cyc(0, 0, 0, 1, 16'hFFFF);
        cyc(0, 0, 1, 1, 16'h0000);

        phase = "R3";
        cyc(1, 2'd0, 0, 1, 16'hBEEF);
        for (int i = 0; i < 8; i++) cyc(0, 0, (i != 2), 1, 16'hFFBF);
        idle(4, 1);

        phase = "R4";
        cyc(1, 2'd1, 0, 1, 16'h0);
        n = 0;
        while (!ready && n < 40) begin
            cyc((n == 2), 2'd3, n[0], 1, 16'h5A5A);
            n++;
        end
        chk(n == SECT, "R4", "busy length with ignored start", DW'(n), DW'(SECT));

        phase = "R6";
        cyc(1, 2'd2, 1, 1, 16'h0F0F);
        #1 chk(ready === 1'b0, "R6", "start in recovery", DW'(ready), 0);
        idle(BLK + RCV + 2, 1);

        phase = "R2";
        cyc(1, 2'd3, 1, 1, 16'h1111);
        for (int i = 0; i < CHIP + RCV + 2; i++) cyc(0, 0, i[0], 1, 16'h2222);

        phase = "R7";
        cyc(1, 2'd3, 0, 1, 16'h3333);
        idle(2, 1);
        for (int i = 0; i < PMIN - 1; i++) cyc(0, 0, 1, 0, 16'h4444);
        idle(1, 1);
        #1 chk(ready === 1'b0, "R7", "short pin pulse ignored", DW'(ready), 0);

        phase = "R9";
        for (int i = 0; i < PMIN + 2; i++) cyc(0, 0, 1, 0, 16'h5555);
        #1 chk(redo === 1'b1, "R9", "erase abort flag", DW'(redo), 1);
        phase = "R8";
        idle(REL + 3, 1);

        phase = "R9";
        cyc(1, 2'd0, 0, 1, 16'h6666);
        idle(2, 1);
        for (int i = 0; i < PMIN + 1; i++) cyc(0, 0, 0, 0, 16'h7777);
        idle(REL + 2, 1);
        #1 chk(redo === 1'b1, "R9", "program abort keeps flag", DW'(redo), 1);
        cyc(1, 2'd1, 0, 1, 16'h8888);
        #1 chk(redo === 1'b0, "R9", "erase start clears flag", DW'(redo), 0);
        idle(SECT + RCV + 2, 1);

        phase = "R8";
        for (int i = 0; i < PMIN + 3; i++) cyc(0, 0, 1, 0, 16'h9999);
        idle(REL + 3, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule